// File: doc/BRIEF.md
# Instruction-End Trap Dispatcher

This block makes the decision a processor core needs at every instruction boundary. It can service a pending interrupt, take a trap through a vector, fetch the next instruction, or fall back to idle. While an instruction runs, the block watches each acknowledged memory access. It holds two kinds of trap request in sticky latches until the boundary: a trap flagged by the memory management unit, and a yellow-zone stack limit violation.

When the sequencer raises the boundary strobe, the block answers combinationally in that same cycle. An interrupt that outranks the processor priority wins. Otherwise any pending request or the trace flag leads to a trap. The vector index is picked by fixed rank, and both request latches are cleared. Taking the yellow stack trap opens a yellow vector flow and pulses an error-bit set. While that flow is open, new yellow violations are not recorded. Completed console memory accesses discard any pending requests, so console traffic never traps the processor.

Top module: `trap_dispatch`

## Requirements
- R1: After reset both request latches and the yellow flow flag are clear, and `action_o` is 0 (none), `vec_idx_o` is 0 and `ysv_err_set_o` is 0 while `instr_end_i` is low.
- R2: At a boundary (`instr_end_i`=1) with `int_pri_i` strictly greater than `psw_pri_i`, `action_o` is 3 (interrupt) even when trap requests are pending, and the pending requests are kept. Equal priority does not select the interrupt.
- R3: At a boundary without a winning interrupt, a latched request, a request arriving in the same cycle with `mem_ack_i`, or `psw_trace_i`=1 gives `action_o`=4 (trap).
- R4: On a trap, `vec_idx_o` is 7'b0101010 for an MMU request, else 7'b0000001 for a yellow request, else 7'b0000011 for trace. It is 0 whenever `action_o` is not 4.
- R5: A taken trap clears both request latches, including requests that arrive in that same cycle.
- R6: `mmu_trap_i` with `mem_ack_i` is remembered across any number of cycles until a trap is taken or a console access completes.
- R7: `ysv_trap_i` with `mem_ack_i` is remembered only while the yellow flow flag is clear. Trap flags without `mem_ack_i` are ignored.
- R8: `console_done_i` clears both request latches, including requests that arrive in that same cycle.
- R9: Taking the yellow vector pulses `ysv_err_set_o` and sets `in_ysv_flow_o` from the next cycle. `vec_done_i` clears the flag.
- R10: At a boundary with nothing pending and no winning interrupt, `action_o` is 1 (fetch) when `run_i`=1 and 2 (idle) when `run_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_ack_i | input | 1 | Memory access acknowledged this cycle |
| mmu_trap_i | input | 1 | MMU trap flag returned with the access |
| ysv_trap_i | input | 1 | Yellow stack violation flag returned with the access |
| console_done_i | input | 1 | Console memory access completes this cycle |
| instr_end_i | input | 1 | Instruction boundary decision strobe |
| int_pri_i | input | 3 | Priority of the highest pending interrupt |
| psw_pri_i | input | 3 | Processor status priority |
| psw_trace_i | input | 1 | Trace flag of the processor status |
| run_i | input | 1 | CPU running |
| vec_done_i | input | 1 | Vector flow completed |
| action_o | output | 3 | 0 none, 1 fetch, 2 idle, 3 interrupt, 4 trap |
| vec_idx_o | output | 7 | Vector index for a trap |
| ysv_err_set_o | output | 1 | Pulse: set the yellow stack error bit |
| in_ysv_flow_o | output | 1 | Yellow vector flow active |

## Verification
The assertions assume that the sequencer never raises `console_done_i` in a boundary cycle. They also assume that `vec_done_i` never coincides with a boundary, because console accesses and vector flows do not overlap with instruction end. Under those assumptions the set and clear of each latch never meet in a way the properties leave unspecified. The random stimulus respects this: it draws `console_done_i` and `vec_done_i` only in cycles where the boundary strobe is low. The directed cases separately cover same-cycle arrival at a boundary, console clearing of a same-cycle request, and yellow violations during an open yellow flow.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_FETCH = 3'd1,
    ACT_IDLE  = 3'd2,
    ACT_INTR  = 3'd3,
    ACT_TRAP  = 3'd4
  } act_e;

  localparam int VEC_W = 7;
  localparam int N_REQ = 2;   // index 0: mmu, 1: yellow
  localparam int REQ_MMU = 0;
  localparam int REQ_YSV = 1;
  localparam logic [VEC_W-1:0] VEC_MMU   = 7'b0101010;
  localparam logic [VEC_W-1:0] VEC_YSV   = 7'b0000001;
  localparam logic [VEC_W-1:0] VEC_TRACE = 7'b0000011;
endpackage

// File: rtl/dsp_req_latch.sv
module dsp_req_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (clr_i)    q_o[g] <= 1'b0;   // clear wins: same-cycle arrivals already consumed
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dsp_flow_flag.sv
module dsp_flow_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/dsp_arbiter.sv
module dsp_arbiter
  import dsp_pkg::*;
#(
  parameter int PRI_W = 3
) (
  input  logic             instr_end_i,
  input  logic [PRI_W-1:0] int_pri_i,
  input  logic [PRI_W-1:0] psw_pri_i,
  input  logic             trace_i,
  input  logic             run_i,
  input  logic [N_REQ-1:0] req_i,
  output act_e             action_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             take_ysv_o
);
  always_comb begin
    action_o   = ACT_NONE;
    vec_o      = '0;
    take_ysv_o = 1'b0;
    if (instr_end_i) begin
      if (int_pri_i > psw_pri_i) begin
        action_o = ACT_INTR;
      end else if (|req_i || trace_i) begin
        action_o = ACT_TRAP;
        if (req_i[REQ_MMU]) begin
          vec_o = VEC_MMU;
        end else if (req_i[REQ_YSV]) begin
          vec_o      = VEC_YSV;
          take_ysv_o = 1'b1;
        end else begin
          vec_o = VEC_TRACE;
        end
      end else if (run_i) begin
        action_o = ACT_FETCH;
      end else begin
        action_o = ACT_IDLE;
      end
    end
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import dsp_pkg::*;
#(
  parameter int PRI_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mem_ack_i,
  input  logic             mmu_trap_i,
  input  logic             ysv_trap_i,
  input  logic             console_done_i,
  input  logic             instr_end_i,
  input  logic [PRI_W-1:0] int_pri_i,
  input  logic [PRI_W-1:0] psw_pri_i,
  input  logic             psw_trace_i,
  input  logic             run_i,
  input  logic             vec_done_i,
  output logic [2:0]       action_o,
  output logic [VEC_W-1:0] vec_idx_o,
  output logic             ysv_err_set_o,
  output logic             in_ysv_flow_o
);
  logic [N_REQ-1:0] req_q, req_in, req_all;
  logic             flow_q, take_ysv, req_clr;
  act_e             action;

  assign req_in[REQ_MMU] = mem_ack_i & mmu_trap_i;
  assign req_in[REQ_YSV] = mem_ack_i & ysv_trap_i & ~flow_q;
  assign req_all         = req_q | req_in;

  dsp_arbiter #(.PRI_W(PRI_W)) u_arb (
    .instr_end_i (instr_end_i),
    .int_pri_i   (int_pri_i),
    .psw_pri_i   (psw_pri_i),
    .trace_i     (psw_trace_i),
    .run_i       (run_i),
    .req_i       (req_all),
    .action_o    (action),
    .vec_o       (vec_idx_o),
    .take_ysv_o  (take_ysv)
  );

  assign req_clr = (action == ACT_TRAP) | console_done_i;

  dsp_req_latch #(.N(N_REQ)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_in),
    .clr_i  (req_clr),
    .q_o    (req_q)
  );

  dsp_flow_flag u_flow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (take_ysv),
    .clr_i  (vec_done_i),
    .q_o    (flow_q)
  );

  assign action_o      = action;
  assign ysv_err_set_o = take_ysv;
  assign in_ysv_flow_o = flow_q;
endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk
  import dsp_pkg::*;
#(
  parameter int PRI_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_ack_i,
  input logic             mmu_trap_i,
  input logic             console_done_i,
  input logic             instr_end_i,
  input logic [PRI_W-1:0] int_pri_i,
  input logic [PRI_W-1:0] psw_pri_i,
  input logic             run_i,
  input logic [2:0]       action_o,
  input logic [VEC_W-1:0] vec_idx_o,
  input logic             ysv_err_set_o,
  input logic             in_ysv_flow_o,
  input logic [N_REQ-1:0] req_q
);
  assert_idle_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_end_i |-> action_o == 3'd0);
  assert_intr_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_end_i && int_pri_i > psw_pri_i) |-> action_o == 3'd3);
  assert_vec_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o != 3'd4 |-> vec_idx_o == '0);
  assert_vec_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 3'd4 |-> vec_idx_o != '0);
  assert_trap_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 3'd4 |=> req_q == '0);
  assert_mmu_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ack_i && mmu_trap_i && !console_done_i && action_o != 3'd4) |=> req_q[REQ_MMU]);
  assert_console_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    console_done_i |=> req_q == '0);
  assert_flow_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ysv_err_set_o |=> in_ysv_flow_o);
  assert_fetch_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 3'd1 |-> run_i);
endmodule

bind trap_dispatch trap_dispatch_chk #(.PRI_W(PRI_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mem_ack_i      (mem_ack_i),
  .mmu_trap_i     (mmu_trap_i),
  .console_done_i (console_done_i),
  .instr_end_i    (instr_end_i),
  .int_pri_i      (int_pri_i),
  .psw_pri_i      (psw_pri_i),
  .run_i          (run_i),
  .action_o       (action_o),
  .vec_idx_o      (vec_idx_o),
  .ysv_err_set_o  (ysv_err_set_o),
  .in_ysv_flow_o  (in_ysv_flow_o),
  .req_q          (req_q)
);

// File: tb/tb_trap_dispatch.sv
module tb_trap_dispatch;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ack = 0, mmu = 0, ysv = 0, con = 0, ie = 0, tr = 0, run = 0, vfd = 0;
  logic [2:0] ip = 0, pp = 0;
  logic [2:0] act;
  logic [6:0] vec;
  logic err, flow;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model state
  bit m_mmu = 0, m_ysv = 0, m_flow = 0;

  always #10 clk = ~clk;

  trap_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_ack_i(ack), .mmu_trap_i(mmu), .ysv_trap_i(ysv),
    .console_done_i(con), .instr_end_i(ie), .int_pri_i(ip), .psw_pri_i(pp),
    .psw_trace_i(tr), .run_i(run), .vec_done_i(vfd),
    .action_o(act), .vec_idx_o(vec), .ysv_err_set_o(err), .in_ysv_flow_o(flow));

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check mid-low phase, advance model at posedge
  task automatic cyc(string tag, bit a, bit m, bit y, bit c, bit e, bit v,
                     int i_p, int p_p, bit t, bit r);
    bit im, iy, rm, ry;
    int ea, ev;
    bit ee;
    @(negedge clk);
    ack = a; mmu = m; ysv = y; con = c; ie = e; vfd = v;
    ip = 3'(i_p); pp = 3'(p_p); tr = t; run = r;
    #2;
    im = a & m; iy = a & y & !m_flow;
    rm = m_mmu | im; ry = m_ysv | iy;
    ev = 0; ee = 0;
    if (!e) ea = 0;
    else if (i_p > p_p) ea = 3;
    else if (rm | ry | t) begin
      ea = 4;
      if (rm) ev = 7'b0101010;
      else if (ry) begin ev = 7'b0000001; ee = 1; end
      else ev = 7'b0000011;
    end else if (r) ea = 1;
    else ea = 2;
    chk(tag, "action", int'(act), ea);
    chk(tag, "vector", int'(vec), ev);
    chk(tag, "err_set", int'(err), int'(ee));
    chk(tag, "flow", int'(flow), int'(m_flow));
    if (ea == 4 || c) begin m_mmu = 0; m_ysv = 0; end
    else begin m_mmu = rm; m_ysv = ry; end
    if (ee) m_flow = 1; else if (v) m_flow = 0;
    @(posedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    #3;
    // R1: reset state
    chk("R1", "action_rst", int'(act), 0);
    chk("R1", "vector_rst", int'(vec), 0);
    chk("R1", "flow_rst", int'(flow), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 0,0,0,0,0,0, 0,7,0,1);
    cyc("R10", 0,0,0,0,1,0, 0,7,0,1);
    cyc("R10", 0,0,0,0,1,0, 0,7,0,0);
    // R11 style ignore: flags without ack
    cyc("R7", 0,1,1,0,0,0, 0,7,0,1);
    cyc("R7", 0,0,0,0,1,0, 0,7,0,1);
    // R6: mmu held over idle cycles
    cyc("R6", 1,1,0,0,0,0, 0,7,0,1);
    cyc("R6", 0,0,0,0,0,0, 0,7,0,1);
    cyc("R6", 1,0,0,0,0,0, 0,7,0,1);
    cyc("R4", 0,0,0,0,1,0, 0,7,0,1);
    cyc("R5", 0,0,0,0,1,0, 0,7,0,1);
    // R2: interrupt wins, request retained; equal priority not interrupt
    cyc("R2", 1,0,1,0,0,0, 0,3,0,1);
    cyc("R2", 0,0,0,0,1,0, 5,3,0,1);
    cyc("R9", 0,0,0,0,1,0, 3,3,0,1);
    // R7: yellow ignored during flow
    cyc("R7", 1,0,1,0,0,0, 0,7,0,1);
    cyc("R7", 0,0,0,0,1,0, 0,7,0,1);
    cyc("R9", 0,0,0,0,0,1, 0,7,0,1);
    cyc("R9", 0,0,0,0,0,0, 0,7,0,1);
    // R8: console clears held and same-cycle requests
    cyc("R8", 1,1,1,0,0,0, 0,7,0,1);
    cyc("R8", 0,0,0,1,0,0, 0,7,0,1);
    cyc("R8", 0,0,0,0,1,0, 0,7,0,1);
    cyc("R8", 1,1,1,1,0,0, 0,7,0,1);
    cyc("R8", 0,0,0,0,1,0, 0,7,0,1);
    // R4: priority order
    cyc("R4", 1,1,1,0,1,0, 0,7,1,1);
    cyc("R4", 1,0,1,0,1,0, 0,7,1,1);
    cyc("R9", 0,0,0,0,0,1, 0,7,0,1);
    cyc("R4", 0,0,0,0,1,0, 0,7,1,1);
    // R3: same-cycle arrival joins decision
    cyc("R3", 1,1,0,0,1,0, 0,7,0,1);
    cyc("R5", 0,0,0,0,1,0, 0,7,0,0);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit e, c, v;
      e = ($urandom % 10) < 3;
      c = !e && (($urandom % 20) == 0);
      v = !e && (($urandom % 10) == 0);
      cyc("R3", ($urandom % 2) == 1, ($urandom % 7) == 0, ($urandom % 7) == 0,
          c, e, v, int'($urandom % 8), int'($urandom % 8),
          ($urandom % 10) == 0, ($urandom % 5) != 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule